// File: doc/BRIEF.md
# Periodic Self-Refresh Window Timer

This block lets a memory whose internal self-refresh runs at a fixed rate keep its contents while being refreshed at a much longer, programmable interval. The host picks a long period, typically several seconds, expressed in ticks of a prescaled timebase. At each period boundary the timer switches the memory into self-refresh. After a window that is long enough for one complete internal refresh sweep (for example 64 ms), it switches self-refresh off again. The memory then sits without refresh until the next boundary.

The timer emits a one-cycle request to enter self-refresh and a one-cycle request to leave it, together with a level that shows whether self-refresh is currently requested. Both the period and the window length are sampled only at a period boundary. An illegal window length holds self-refresh on permanently and raises an error flag. When the enable input is low, self-refresh is forced on and all timing state is cleared. Raising the enable again counts as a period boundary at which self-refresh is already on.

Top module: `srw_timer`

## Requirements
- R1: Out of reset, `sr_on_o` is 1, `sr_enter_o` and `sr_exit_o` are 0, and `cfg_err_o` is 0.
- R2: The first enabled clock cycle is a period boundary at which self-refresh stays on, so no enter pulse is produced. The `window_i`-th tick after a boundary turns self-refresh off and raises `sr_exit_o`.
- R3: The `period_i`-th tick after a boundary starts a new period, turns self-refresh on and raises `sr_enter_o`. Successive periods repeat with the same tick counts.
- R4: Clock cycles with `tick_i` low do not advance the timing, however many of them pass.
- R5: A value written to `period_i` or `window_i` in the middle of a period is used only from the next boundary. The current period and window finish with the old values.
- R6: A loaded window length of 0, or one greater than or equal to the loaded period, sets `cfg_err_o` at that boundary and holds `sr_on_o` at 1 with no exit pulse. A legal value loaded at a later boundary clears the flag.
- R7: While `en_i` is low, `sr_on_o` is 1 and `cfg_err_o` is 0, ticks have no effect, and the period restarts from zero when `en_i` rises again. If self-refresh was off when `en_i` fell, an enter pulse is produced.
- R8: `sr_enter_o` is high for exactly the cycle in which `sr_on_o` rises, and `sr_exit_o` is high for exactly the cycle in which it falls. The two pulses are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Timer enable; when low, self-refresh is forced on |
| tick_i | input | 1 | One-cycle strobe from the prescaled timebase |
| period_i | input | CNT_W | Refresh period in ticks |
| window_i | input | CNT_W | Self-refresh window length in ticks |
| sr_on_o | output | 1 | Self-refresh currently requested |
| sr_enter_o | output | 1 | One-cycle request to enter self-refresh |
| sr_exit_o | output | 1 | One-cycle request to leave self-refresh |
| cfg_err_o | output | 1 | Loaded window length is illegal |

## Verification
Every output is a flop, so each result is due at the same rising edge that samples the tick, or the enable change, that causes it. Nothing is delayed by an extra stage. The bench drives inputs on the falling edge, lets one rising edge pass, and reads the outputs at the next falling edge, which is exactly the cycle the result is due. Each pulse is checked again one falling edge later to confirm it has dropped. Boundary positions are counted in ticks from the last boundary in the bench's own sequence, never read from the design.

// File: rtl/srw_pkg.sv
package srw_pkg;

    // Decision taken by the controller in one clock cycle.
    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_FORCE,
        ACT_START,
        ACT_WRAP,
        ACT_CLOSE
    } srw_act_e;

    // Registered control outputs of the timer.
    typedef struct packed {
        logic en;
        logic on;
        logic enter;
        logic exit;
    } srw_ctl_t;

endpackage

// File: rtl/srw_cfg_shadow.sv
module srw_cfg_shadow #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             clear,
    input  logic [CNT_W-1:0] per_in,
    input  logic [CNT_W-1:0] win_in,
    output logic [CNT_W-1:0] per_o,
    output logic [CNT_W-1:0] win_o,
    output logic             err_o
);

    typedef struct packed {
        logic [CNT_W-1:0] per;
        logic [CNT_W-1:0] win;
        logic             err;
    } shadow_t;

    shadow_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d = '0;
        end else if (load) begin
            sh_d.per = per_in;
            sh_d.win = win_in;
            // An empty window, or one that fills the period, cannot close.
            sh_d.err = (win_in == '0) || (win_in >= per_in);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign per_o = sh_q.per;
    assign win_o = sh_q.win;
    assign err_o = sh_q.err;

endmodule

// File: rtl/srw_tick_ctr.sv
module srw_tick_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    input  logic [CNT_W-1:0] win,
    output logic             wrap_o,
    output logic             win_hit_o
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } ctr_t;

    ctr_t             ctr_d, ctr_q;
    logic [CNT_W-1:0] nxt;

    always_comb begin
        nxt       = ctr_q.count + 1'b1;
        // A limit of zero wraps on every tick so new settings still load.
        wrap_o    = tick && (nxt >= limit);
        win_hit_o = tick && (nxt == win);
        ctr_d     = ctr_q;
        if (clear || wrap_o) ctr_d.count = '0;
        else if (tick)       ctr_d.count = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

endmodule

// File: rtl/srw_timer.sv
module srw_timer
    import srw_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] window_i,
    output logic             sr_on_o,
    output logic             sr_enter_o,
    output logic             sr_exit_o,
    output logic             cfg_err_o
);

    srw_ctl_t         ctl_d, ctl_q;
    srw_act_e         act;
    logic             ctr_clear, sh_load, sh_clear;
    logic             wrap, win_hit;
    logic [CNT_W-1:0] per_sh, win_sh;
    logic             err_sh;

    srw_cfg_shadow #(.CNT_W(CNT_W)) u_shadow (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (sh_load),
        .clear  (sh_clear),
        .per_in (period_i),
        .win_in (window_i),
        .per_o  (per_sh),
        .win_o  (win_sh),
        .err_o  (err_sh)
    );

    srw_tick_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctr_clear),
        .tick      (tick_i),
        .limit     (per_sh),
        .win       (win_sh),
        .wrap_o    (wrap),
        .win_hit_o (win_hit)
    );

    always_comb begin
        if (!en_i)                               act = ACT_FORCE;
        else if (!ctl_q.en)                      act = ACT_START;
        else if (wrap)                           act = ACT_WRAP;
        else if (win_hit && !err_sh && ctl_q.on) act = ACT_CLOSE;
        else                                     act = ACT_IDLE;
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.en    = en_i;
        ctl_d.enter = 1'b0;
        ctl_d.exit  = 1'b0;
        ctr_clear   = 1'b0;
        sh_load     = 1'b0;
        sh_clear    = 1'b0;
        unique case (act)
            ACT_FORCE: begin
                ctl_d.on    = 1'b1;
                ctl_d.enter = !ctl_q.on;
                ctr_clear   = 1'b1;
                sh_clear    = 1'b1;
            end
            ACT_START: begin
                ctl_d.on  = 1'b1;
                ctr_clear = 1'b1;
                sh_load   = 1'b1;
            end
            ACT_WRAP: begin
                ctl_d.on    = 1'b1;
                ctl_d.enter = !ctl_q.on;
                sh_load     = 1'b1;
            end
            ACT_CLOSE: begin
                ctl_d.on   = 1'b0;
                ctl_d.exit = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{en: 1'b0, on: 1'b1, enter: 1'b0, exit: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign sr_on_o    = ctl_q.on;
    assign sr_enter_o = ctl_q.enter;
    assign sr_exit_o  = ctl_q.exit;
    assign cfg_err_o  = err_sh;

endmodule

// File: rtl/srw_timer_chk.sv
module srw_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic tick_i,
    input logic sr_on_o,
    input logic sr_enter_o,
    input logic sr_exit_o,
    input logic cfg_err_o
);

    a_r8_enter_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        sr_enter_o == $rose(sr_on_o));

    a_r8_exit_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit_o == $fell(sr_on_o));

    a_r8_never_both: assert property (@(posedge clk) disable iff (!rst_n)
        !(sr_enter_o && sr_exit_o));

    a_r2_exit_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        sr_exit_o |-> $past(tick_i) && $past(en_i));

    a_r6_err_holds_on: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> sr_on_o && !sr_exit_o);

    a_r7_disable_forces_on: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> sr_on_o && !cfg_err_o);

endmodule

bind srw_timer srw_timer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .tick_i     (tick_i),
    .sr_on_o    (sr_on_o),
    .sr_enter_o (sr_enter_o),
    .sr_exit_o  (sr_exit_o),
    .cfg_err_o  (cfg_err_o)
);

// File: tb/srw_timer_test.sv
module srw_timer_test;

    localparam int CNT_W = 32;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             en_i = 1'b0;
    logic             tick_i = 1'b0;
    logic [CNT_W-1:0] period_i = '0;
    logic [CNT_W-1:0] window_i = '0;
    logic             sr_on_o, sr_enter_o, sr_exit_o, cfg_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    srw_timer #(.CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .tick_i     (tick_i),
        .period_i   (period_i),
        .window_i   (window_i),
        .sr_on_o    (sr_on_o),
        .sr_enter_o (sr_enter_o),
        .sr_exit_o  (sr_exit_o),
        .cfg_err_o  (cfg_err_o)
    );

    task automatic chk(string req, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, got, exp);
        end
    endtask

    // Check the three control outputs in the current cycle.
    task automatic chk_out(string req, logic on, logic ent, logic ext);
        chk(req, "sr_on", sr_on_o, on);
        chk(req, "enter", sr_enter_o, ent);
        chk(req, "exit", sr_exit_o, ext);
    endtask

    // One tick; returns at the falling edge after the edge that sampled it.
    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
    endtask

    task automatic ticks_quiet(string req, int n, logic on);
        for (int i = 0; i < n; i++) begin
            do_tick();
            chk_out(req, on, 1'b0, 1'b0);
        end
    endtask

    task automatic t_reset();
        chk_out("R1", 1'b1, 1'b0, 1'b0);
        chk("R1", "cfg_err", cfg_err_o, 1'b0);
    endtask

    task automatic t_basic();
        period_i = 5; window_i = 2;
        @(negedge clk) en_i = 1'b1;
        @(negedge clk);
        chk_out("R2", 1'b1, 1'b0, 1'b0);
        chk("R2", "cfg_err", cfg_err_o, 1'b0);
        ticks_quiet("R2", 1, 1'b1);
        do_tick();
        chk_out("R2", 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk_out("R8", 1'b0, 1'b0, 1'b0);
        ticks_quiet("R3", 2, 1'b0);
        do_tick();
        chk_out("R3", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        chk_out("R8", 1'b1, 1'b0, 1'b0);
        ticks_quiet("R3", 1, 1'b1);
        do_tick();
        chk_out("R3", 1'b0, 1'b0, 1'b1);
        ticks_quiet("R3", 2, 1'b0);
        do_tick();
        chk_out("R3", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_no_tick();
        repeat (20) @(negedge clk);
        chk_out("R4", 1'b1, 1'b0, 1'b0);
        ticks_quiet("R4", 1, 1'b1);
        do_tick();
        chk_out("R4", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_reprogram();
        // Two ticks into a P=5 period; change both settings now.
        period_i = 8; window_i = 3;
        ticks_quiet("R5", 2, 1'b0);
        do_tick();
        chk_out("R5", 1'b1, 1'b1, 1'b0);
        ticks_quiet("R5", 2, 1'b1);
        do_tick();
        chk_out("R5", 1'b0, 1'b0, 1'b1);
        ticks_quiet("R5", 4, 1'b0);
        do_tick();
        chk_out("R5", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_badcfg();
        window_i = 8;
        ticks_quiet("R6", 2, 1'b1);
        do_tick();
        chk_out("R6", 1'b0, 1'b0, 1'b1);
        chk("R6", "cfg_err", cfg_err_o, 1'b0);
        ticks_quiet("R6", 4, 1'b0);
        do_tick();
        chk_out("R6", 1'b1, 1'b1, 1'b0);
        chk("R6", "cfg_err", cfg_err_o, 1'b1);
        ticks_quiet("R6", 16, 1'b1);
        chk("R6", "cfg_err", cfg_err_o, 1'b1);
        window_i = 2;
        ticks_quiet("R6", 8, 1'b1);
        chk("R6", "cfg_err", cfg_err_o, 1'b0);
        ticks_quiet("R6", 1, 1'b1);
        do_tick();
        chk_out("R6", 1'b0, 1'b0, 1'b1);
    endtask

    task automatic t_disable();
        ticks_quiet("R7", 1, 1'b0);
        @(negedge clk) en_i = 1'b0;
        @(negedge clk);
        chk_out("R7", 1'b1, 1'b1, 1'b0);
        chk("R7", "cfg_err", cfg_err_o, 1'b0);
        @(negedge clk);
        chk_out("R8", 1'b1, 1'b0, 1'b0);
        ticks_quiet("R7", 5, 1'b1);
        period_i = 4; window_i = 1;
        @(negedge clk) en_i = 1'b1;
        @(negedge clk);
        chk_out("R7", 1'b1, 1'b0, 1'b0);
        do_tick();
        chk_out("R7", 1'b0, 1'b0, 1'b1);
        ticks_quiet("R7", 2, 1'b0);
        do_tick();
        chk_out("R7", 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_zero_window();
        @(negedge clk) en_i = 1'b0;
        period_i = 4; window_i = 0;
        @(negedge clk) en_i = 1'b1;
        @(negedge clk);
        chk("R6", "cfg_err", cfg_err_o, 1'b1);
        ticks_quiet("R6", 6, 1'b1);
        chk("R6", "cfg_err", cfg_err_o, 1'b1);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_no_tick();
        t_reprogram();
        t_badcfg();
        t_disable();
        t_zero_window();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end

endmodule